// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small load/store processor that runs one instruction at a time. Every instruction is spread over several clock cycles, and the number of cycles depends on its class. The sequencer reads the 6-bit opcode from the instruction register and the zero flag from the ALU. Each cycle it drives the strobes that steer a shared memory, a single shared ALU, the program counter and the register file.

Each instruction starts with two common steps. The first reads the instruction word and increments the PC. The second reads the registers and computes a possible branch target on the ALU. After these, the path splits by instruction class:

| Class | Cycles | Last step |
|---|---|---|
| Unknown opcode | 2 | decode |
| Branch-if-equal | 3 | branch |
| Jump | 3 | jump |
| Register-register | 4 | register write-back |
| Store word | 4 | memory write |
| Load word | 5 | load write-back |

After the last step of any class, the sequencer returns to fetch. The ALU does a different job in each of the first three steps: it adds 4 to the PC, then forms the branch target, then does the work of the instruction. The selects choose its operands and operation in every cycle.

All strobes depend only on the current state. The one exception is the combined PC load enable, which also uses the zero flag.

Top module: `mc_cpu_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the sequencer in the fetch step. Fetch drives the following values:
  - memRead=1, irWrite=1, pcWrite=1 and pcLoad=1.
  - memAddrSel=0 (the PC is the address).
  - aluSrcA=0 (PC), aluSrcB=1 (constant 4), aluOp=0 (add), pcSource=0 (ALU result).
  - All other outputs are 0.
- R2: Fetch is always followed by decode. Decode drives aluSrcA=0 and aluSrcB=3 (sign-extended offset shifted left by two), with aluOp=0. Every write enable is 0 in decode.
- R3: Counting from fetch to the next fetch, instructions take these cycle counts:
  - beq (opcode 6'h04) and j (6'h02): 3 cycles.
  - R-type (6'h00) and sw (6'h2B): 4 cycles.
  - lw (6'h23): 5 cycles.
  - Any other opcode: 2 cycles, returning to fetch after decode.

  The class is taken from the opcode in the decode cycle. Later opcode changes have no effect.
- R4: In the third cycle of lw and sw, the address is formed with aluSrcA=1 (register A), aluSrcB=2 (sign-extended immediate) and aluOp=0. No write enable is asserted.
- R5: The fourth cycle of lw asserts memRead with memAddrSel=1 (ALUOut as the address). The fifth cycle asserts regWrite with wbSel=1 (memory data register) and dstSel=0 (rt).
- R6: The fourth cycle of sw asserts memWrite with memAddrSel=1. regWrite stays 0 for the whole instruction.
- R7: R-type behaves as follows:
  - In its third cycle it drives aluSrcA=1, aluSrcB=0 (register B) and aluOp=2 (function field).
  - In its fourth cycle it asserts regWrite with wbSel=0 (ALUOut) and dstSel=1 (rd).
  - It never asserts memRead or memWrite after fetch.
- R8: The third cycle of beq drives these values:
  - aluSrcA=1, aluSrcB=0 and aluOp=1 (subtract).
  - pcWriteCond=1 with pcSource=1 (ALUOut) and pcWrite=0.

  pcLoad is 1 in that cycle only when aluZero is 1.
- R9: The third cycle of j drives pcWrite=1 and pcLoad=1 with pcSource=2 (jump target). Every other write enable is 0.
- R10: Any write enable or select that a state does not use is 0. aluZero has no effect on any output except pcLoad in the beq third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| aluZero | input | 1 | Zero flag from the ALU |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memAddrSel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| irWrite | output | 1 | Instruction register load |
| pcWrite | output | 1 | Unconditional PC load |
| pcWriteCond | output | 1 | PC load if zero flag set |
| pcLoad | output | 1 | Combined PC load enable |
| aluSrcA | output | 1 | ALU A operand: 0 PC, 1 register A |
| aluSrcB | output | 2 | ALU B operand: 0 B, 1 four, 2 immediate, 3 shifted immediate |
| aluOp | output | 2 | 0 add, 1 subtract, 2 function field |
| pcSource | output | 2 | 0 ALU result, 1 ALUOut, 2 jump target |
| regWrite | output | 1 | Register file write |
| wbSel | output | 1 | Write data: 0 ALUOut, 1 memory data register |
| dstSel | output | 1 | Destination register: 0 rt, 1 rd |

## Verification
The assertions check these relations on every cycle:
- Reset returns the sequencer to fetch.
- Decode follows fetch.
- Every final step goes back to fetch.
- A load's memory read is followed by its write-back.
- A store's memory write is followed by a fetch.
- A register write never occurs in the same cycle as a memory write or an instruction load.
- A conditional PC load comes right after decode.

Only the bench's scenarios can show the rest:
- The exact cycle count of each instruction class.
- The branch outcome under both zero-flag values.
- Routing of an unknown opcode.
- That opcode changes after decode have no effect.
- That a reset in the middle of a load abandons it.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OPC_W  = 6;
  localparam int SEL2_W = 2;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  // ALU operand B choices
  localparam logic [SEL2_W-1:0] SRCB_REG   = 2'd0;
  localparam logic [SEL2_W-1:0] SRCB_FOUR  = 2'd1;
  localparam logic [SEL2_W-1:0] SRCB_IMM   = 2'd2;
  localparam logic [SEL2_W-1:0] SRCB_SHIMM = 2'd3;

  // ALU operation choices
  localparam logic [SEL2_W-1:0] ALU_ADD   = 2'd0;
  localparam logic [SEL2_W-1:0] ALU_SUB   = 2'd1;
  localparam logic [SEL2_W-1:0] ALU_FUNCT = 2'd2;

  // PC source choices
  localparam logic [SEL2_W-1:0] PCS_ALU  = 2'd0;
  localparam logic [SEL2_W-1:0] PCS_OUT  = 2'd1;
  localparam logic [SEL2_W-1:0] PCS_JUMP = 2'd2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_LDADDR, ST_LDREAD, ST_LDWB,
    ST_STADDR, ST_STWRITE, ST_RUN, ST_RWB, ST_BRANCH, ST_JUMP
  } seqState_t;

  typedef struct packed {
    logic              memRead;
    logic              memWrite;
    logic              memAddrSel;
    logic              irWrite;
    logic              pcWrite;
    logic              pcWriteCond;
    logic              aluSrcA;
    logic [SEL2_W-1:0] aluSrcB;
    logic [SEL2_W-1:0] aluOp;
    logic [SEL2_W-1:0] pcSource;
    logic              regWrite;
    logic              wbSel;
    logic              dstSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/mcStateSeq.sv
module mcStateSeq
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output seqState_t        curState
);
  seqState_t nextState;

  always_comb begin
    nextState = ST_FETCH;
    case (curState)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_RTYPE: nextState = ST_RUN;
          OP_LOAD:  nextState = ST_LDADDR;
          OP_STORE: nextState = ST_STADDR;
          OP_BEQ:   nextState = ST_BRANCH;
          OP_JUMP:  nextState = ST_JUMP;
          default:  nextState = ST_FETCH;
        endcase
      end
      ST_LDADDR: nextState = ST_LDREAD;
      ST_LDREAD: nextState = ST_LDWB;
      ST_STADDR: nextState = ST_STWRITE;
      ST_RUN:    nextState = ST_RWB;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nextState;
  end

  // R1: reset lands in fetch
  a_r1_reset_to_fetch: assert property (@(posedge clk)
    rst |=> curState == ST_FETCH);

  // R2: decode always follows fetch
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    curState == ST_FETCH |=> curState == ST_DECODE);

  // R3: every closing step returns to fetch
  a_r3_final_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (curState inside {ST_LDWB, ST_STWRITE, ST_RWB, ST_BRANCH, ST_JUMP})
      |=> curState == ST_FETCH);

  // R3: a load takes the long path
  a_r3_load_path: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_DECODE && opcode == OP_LOAD) |=> curState == ST_LDADDR);
endmodule

// File: rtl/mcStrobeGen.sv
module mcStrobeGen
  import mc_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  seqState_t    curState,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (curState)
      ST_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.pcWrite = 1'b1;
        strobes.aluSrcB = SRCB_FOUR;
      end
      ST_DECODE: strobes.aluSrcB = SRCB_SHIMM;
      ST_LDADDR, ST_STADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_IMM;
      end
      ST_LDREAD: begin
        strobes.memRead    = 1'b1;
        strobes.memAddrSel = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.wbSel    = 1'b1;
      end
      ST_STWRITE: begin
        strobes.memWrite   = 1'b1;
        strobes.memAddrSel = 1'b1;
      end
      ST_RUN: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluOp   = ALU_FUNCT;
      end
      ST_RWB: begin
        strobes.regWrite = 1'b1;
        strobes.dstSel   = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = ALU_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = PCS_OUT;
      end
      ST_JUMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSource = PCS_JUMP;
      end
      default: strobes = '0;
    endcase
  end

  // R10: the three storage writes never overlap
  a_r10_single_writer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.memWrite, strobes.regWrite, strobes.irWrite}));
endmodule

// File: rtl/mc_cpu_ctrl.sv
module mc_cpu_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             aluZero,
  output logic             memRead,
  output logic             memWrite,
  output logic             memAddrSel,
  output logic             irWrite,
  output logic             pcWrite,
  output logic             pcWriteCond,
  output logic             pcLoad,
  output logic             aluSrcA,
  output logic [1:0]       aluSrcB,
  output logic [1:0]       aluOp,
  output logic [1:0]       pcSource,
  output logic             regWrite,
  output logic             wbSel,
  output logic             dstSel
);
  seqState_t    curState;
  ctrlStrobes_t strobes;

  mcStateSeq u_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .curState(curState));

  mcStrobeGen u_gen (
    .clk(clk), .rst(rst), .curState(curState), .strobes(strobes));

  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign memAddrSel  = strobes.memAddrSel;
  assign irWrite     = strobes.irWrite;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOp       = strobes.aluOp;
  assign pcSource    = strobes.pcSource;
  assign regWrite    = strobes.regWrite;
  assign wbSel       = strobes.wbSel;
  assign dstSel      = strobes.dstSel;
  assign pcLoad      = strobes.pcWrite | (strobes.pcWriteCond & aluZero);

  // R5: a load's data read is followed by its write-back from memory data
  a_r5_read_then_wb: assert property (@(posedge clk) disable iff (rst)
    (memRead && memAddrSel) |=> (regWrite && wbSel));

  // R6: a store's memory write is followed by a fresh fetch
  a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> (irWrite && !regWrite));

  // R8: the conditional PC load comes right after decode
  a_r8_cond_after_decode: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |-> $past(aluSrcB == 2'd3 && !irWrite));
endmodule

// File: tb/tb_mc_cpu_ctrl.sv
module tb_mc_cpu_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic aluZero = 1'b0;
  logic memRead, memWrite, memAddrSel, irWrite, pcWrite, pcWriteCond, pcLoad;
  logic aluSrcA, regWrite, wbSel, dstSel;
  logic [1:0] aluSrcB, aluOp, pcSource;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  int mStep = 0;
  int mCls = 5;

  always #5 clk = ~clk;

  mc_cpu_ctrl dut (
    .clk(clk), .rst(rst), .opcode(opcode), .aluZero(aluZero),
    .memRead(memRead), .memWrite(memWrite), .memAddrSel(memAddrSel),
    .irWrite(irWrite), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .pcLoad(pcLoad), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
    .pcSource(pcSource), .regWrite(regWrite), .wbSel(wbSel), .dstSel(dstSel));

  // class: 0 R-type, 1 lw, 2 sw, 3 beq, 4 j, 5 unknown
  function automatic int classify(input logic [5:0] op);
    case (op)
      6'h00: return 0;
      6'h23: return 1;
      6'h2B: return 2;
      6'h04: return 3;
      6'h02: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int lenOf(input int cls);
    case (cls)
      0, 2: return 4;
      1: return 5;
      3, 4: return 3;
      default: return 2;
    endcase
  endfunction

  // order: memRead memWrite memAddrSel irWrite pcWrite pcWriteCond
  //        aluSrcA aluSrcB aluOp pcSource regWrite wbSel dstSel
  function automatic logic [15:0] expVec(input int step, input int cls);
    logic mr = 0, mw = 0, ma = 0, ir = 0, pw = 0, pc = 0, sa = 0, rw = 0, wb = 0, ds = 0;
    logic [1:0] sb = 0, op = 0, ps = 0;
    if (step == 0) begin mr = 1; ir = 1; pw = 1; sb = 1; end
    else if (step == 1) sb = 3;
    else if (step == 2) begin
      if (cls == 0) begin sa = 1; op = 2; end
      else if (cls == 1 || cls == 2) begin sa = 1; sb = 2; end
      else if (cls == 3) begin sa = 1; op = 1; pc = 1; ps = 1; end
      else if (cls == 4) begin pw = 1; ps = 2; end
    end else if (step == 3) begin
      if (cls == 0) begin rw = 1; ds = 1; end
      else if (cls == 1) begin mr = 1; ma = 1; end
      else if (cls == 2) begin mw = 1; ma = 1; end
    end else if (step == 4) begin rw = 1; wb = 1; end
    return {mr, mw, ma, ir, pw, pc, sa, sb, op, ps, rw, wb, ds};
  endfunction

  function automatic string reqTag(input int step, input int cls);
    if (step == 0) return "R1";
    if (step == 1) return "R2";
    if (step == 4) return "R5";
    if (step == 3) return (cls == 1) ? "R5" : (cls == 2) ? "R6" : "R7";
    case (cls)
      0: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference: step within instruction and class chosen at decode
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) mStep <= 0;
    else if (mStep == 1) begin
      mCls  <= classify(opcode);
      mStep <= (lenOf(classify(opcode)) == 2) ? 0 : 2;
    end else if (mStep == lenOf(mCls) - 1 || mStep == 0) begin
      mStep <= (mStep == 0) ? 1 : 0;
    end else mStep <= mStep + 1;
  end

  always @(negedge clk) begin
    #2;
    if (started) begin
      logic [15:0] act, exp;
      logic expLoad;
      act = {memRead, memWrite, memAddrSel, irWrite, pcWrite, pcWriteCond,
             aluSrcA, aluSrcB, aluOp, pcSource, regWrite, wbSel, dstSel};
      exp = expVec(mStep, mCls);
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s strobes step %0d cls %0d actual %h expected %h",
                 reqTag(mStep, mCls), mStep, mCls, act, exp);
      end
      expLoad = (mStep == 0) || (mStep == 2 && mCls == 4) ||
                (mStep == 2 && mCls == 3 && aluZero);
      checks++;
      if (pcLoad !== expLoad) begin
        errors++;
        $display("FAIL %s pcLoad step %0d cls %0d actual %b expected %b",
                 (mCls == 3) ? "R8" : "R10", mStep, mCls, pcLoad, expLoad);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R3 watchdog expired actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // starts on a negedge in fetch; counts cycles until the next fetch (R3)
  task automatic runInstr(input logic [5:0] op, input logic z, input int expLen,
                          input bit scramble);
    int cnt = 0;
    opcode  = op;
    aluZero = z;
    do begin
      @(negedge clk);
      cnt++;
      if (scramble && cnt == 2) opcode = ~op;
    end while (irWrite !== 1'b1 && cnt < 20);
    checks++;
    if (cnt != expLen) begin
      errors++;
      $display("FAIL R3 length op %h actual %0d expected %0d", op, cnt, expLen);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    runInstr(6'h23, 1'b0, 5, 1'b0);  // R5 load
    runInstr(6'h2B, 1'b1, 4, 1'b0);  // R6 store
    runInstr(6'h00, 1'b1, 4, 1'b0);  // R7 and R10: zero flag ignored
    runInstr(6'h04, 1'b1, 3, 1'b0);  // R8 taken
    runInstr(6'h04, 1'b0, 3, 1'b0);  // R8 not taken
    runInstr(6'h02, 1'b0, 3, 1'b0);  // R9 jump
    runInstr(6'h3F, 1'b1, 2, 1'b0);  // R3 unknown opcode
    runInstr(6'h23, 1'b1, 5, 1'b1);  // R3 opcode change after decode ignored
    runInstr(6'h2B, 1'b0, 4, 1'b1);
    runInstr(6'h04, 1'b1, 3, 1'b1);
    // R1: reset in the middle of a load
    opcode = 6'h23;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (irWrite !== 1'b1 || memAddrSel !== 1'b0) begin
      errors++;
      $display("FAIL R1 mid-load reset actual irWrite %b expected 1", irWrite);
    end
    runInstr(6'h00, 1'b0, 4, 1'b0);
    runInstr(6'h23, 1'b0, 5, 1'b0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule